// File: doc/BRIEF.md
# Double-Buffered Endpoint Packet Buffer

This block stores packets for a single one-way endpoint in two ping-pong banks of 64 bytes each. The producer side writes bytes one per strobe into whichever bank is currently being filled. It then closes that packet with a commit strobe that carries the packet length. The consumer side reads bytes one per strobe from the oldest closed packet and hands the bank back with a release strobe. Because the two banks are independent, one packet can be filled while the other is drained in the same cycles.

The block has two ports, one facing the serial host bus and one facing the USB engine. A direction parameter decides which of them produces and which consumes. In the IN variant the host side produces and the USB side consumes. In the OUT variant the roles are swapped. A single event pulse tells an interrupt controller that a packet has arrived (OUT) or has been sent (IN). A level output shows whether a free bank is available to the producer. Two sticky error flags record reads from an empty buffer and writes that could not be stored. A synchronous flush clears everything in one cycle.

Top module: `pingpong_pkt_buf`

## Requirements
- R1: After reset: head_valid=0, head_cnt=0, buf_avail=1, ev_pkt=0, underflow=0, overflow=0, and both data outputs are 0.
- R2: Producer writes land at offsets 0,1,2,... of the bank being filled, and nothing is visible before the commit. An accepted commit marks that bank full with count min(len,64), where len is the 7-bit length input (values 65..127 store 64).
- R3: Each consumer read strobe returns the next byte of the oldest full bank, starting at offset 0, on the consumer data output in the cycle after the strobe. In cycles after no accepted read, that output is 0. head_cnt shows the count of the oldest full bank.
- R4: Packets are consumed in commit order. A release empties the oldest bank, restarts the read offset at 0, and exposes the other packet if one is held.
- R5: The producer may write into the free bank in the same cycles in which the consumer reads the full bank, with no effect on either stream.
- R6: With both banks full, buf_avail=0. Producer writes are dropped and set overflow, producer commits are ignored, and no stored byte changes.
- R7: A commit with length 0 makes a full bank with head_cnt=0, which is released like any other packet.
- R8: A read strobe while both banks are empty returns 0 and sets underflow. Underflow then stays set until reset or flush.
- R9: A 65th write into one bank is dropped and sets overflow, which stays set until reset or flush. The first 64 bytes read back unchanged.
- R10: Flush empties both banks and clears counts, fill offset, read offset, bank order and both sticky flags in one cycle. The next packet starts at offset 0.
- R11: With DIR=IN (1) the host side produces and the USB side consumes, and ev_pkt pulses for one cycle after each accepted release. With DIR=OUT (0) the USB side produces and the host side consumes, and ev_pkt pulses for one cycle after each accepted commit. The producer side's data output stays 0, and the consumer side's din and len inputs are ignored.
- R12: A release while both banks are empty is ignored: no ev_pkt pulse and no state change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous clear of both banks and flags |
| spi_stb | input | 1 | Host side byte strobe (write when producer, read when consumer) |
| spi_done | input | 1 | Host side commit (producer) or release (consumer) |
| spi_din | input | DATA_W | Host side write byte |
| spi_len | input | CNT_W | Host side commit length |
| spi_dout | output | DATA_W | Host side read byte |
| usb_stb | input | 1 | USB side byte strobe |
| usb_done | input | 1 | USB side commit or release |
| usb_din | input | DATA_W | USB side write byte |
| usb_len | input | CNT_W | USB side commit length |
| usb_dout | output | DATA_W | USB side read byte |
| head_valid | output | 1 | Oldest packet is present |
| head_cnt | output | CNT_W | Byte count of the oldest packet |
| buf_avail | output | 1 | A bank is free for the producer |
| ev_pkt | output | 1 | One-cycle packet arrived/sent event |
| underflow | output | 1 | Sticky: read from empty buffer |
| overflow | output | 1 | Sticky: write dropped |

## Verification
The hardest state to reach is both banks full while the consumer is partway through the older packet. In that state a dropped write must leave no trace in the bank that is filled later. The stimulus gets there by strobing producer and consumer in the same cycles: a second packet is committed while the first is half read. A write and a commit are then pushed against the full buffer. After both packets are released, the bench checks that a new packet reads from offset 0 with its own bytes. A separate run of 65 writes then reaches the per-bank limit, and the zero-length and empty-release cases are driven from the same ports.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

    // Default geometry of one endpoint buffer
    localparam int DEF_DATA_W     = 8;
    localparam int DEF_BANK_BYTES = 64;
    localparam int NUM_BANKS      = 2;

    // Which port produces: IN means host side fills, USB side drains
    typedef enum logic {
        DIR_OUT = 1'b0,
        DIR_IN  = 1'b1
    } ep_dir_e;

    // Producer requests after port mapping
    typedef struct packed {
        logic wr;
        logic commit;
    } prod_ctl_t;

    // Consumer requests after port mapping
    typedef struct packed {
        logic rd;
        logic rel;
    } cons_ctl_t;

    // Decoded outcome of one cycle of requests
    typedef struct packed {
        logic accept_wr;
        logic drop_wr;
        logic accept_commit;
        logic accept_rd;
        logic miss_rd;
        logic accept_rel;
    } ctl_dec_t;

    // Clamp a requested packet length to the bank size
    function automatic int clamp_len(input int len, input int lim);
        return (len > lim) ? lim : len;
    endfunction

endpackage

// File: rtl/pktbuf_portmap.sv
module pktbuf_portmap
    import pktbuf_pkg::*;
#(
    parameter ep_dir_e DIR    = DIR_IN,
    parameter int      DATA_W = DEF_DATA_W,
    parameter int      CNT_W  = 7
) (
    input  logic              spi_stb,
    input  logic              spi_done,
    input  logic [DATA_W-1:0] spi_din,
    input  logic [CNT_W-1:0]  spi_len,
    output logic [DATA_W-1:0] spi_dout,
    input  logic              usb_stb,
    input  logic              usb_done,
    input  logic [DATA_W-1:0] usb_din,
    input  logic [CNT_W-1:0]  usb_len,
    output logic [DATA_W-1:0] usb_dout,
    input  logic [DATA_W-1:0] rdata,
    output prod_ctl_t         prod,
    output logic [DATA_W-1:0] prod_data,
    output logic [CNT_W-1:0]  prod_len,
    output cons_ctl_t         cons
);

    localparam logic HOST_FILLS = (DIR == DIR_IN);

    // Producer side selection
    assign prod.wr     = HOST_FILLS ? spi_stb  : usb_stb;
    assign prod.commit = HOST_FILLS ? spi_done : usb_done;
    assign prod_data   = HOST_FILLS ? spi_din  : usb_din;
    assign prod_len    = HOST_FILLS ? spi_len  : usb_len;

    // Consumer side selection
    assign cons.rd  = HOST_FILLS ? usb_stb  : spi_stb;
    assign cons.rel = HOST_FILLS ? usb_done : spi_done;

    // Read data only reaches the consumer; producer output held at zero
    assign usb_dout = HOST_FILLS ? rdata : '0;
    assign spi_dout = HOST_FILLS ? '0 : rdata;

endmodule

// File: rtl/pktbuf_banks.sv
module pktbuf_banks
    import pktbuf_pkg::*;
#(
    parameter int DATA_W     = DEF_DATA_W,
    parameter int BANK_BYTES = DEF_BANK_BYTES,
    parameter int PTR_W      = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_bank,
    input  logic [PTR_W-1:0]  wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_bank,
    input  logic [PTR_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] bank_word [NUM_BANKS];

    // One storage array per bank, written only when selected
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [DATA_W-1:0] store [BANK_BYTES];

        always_ff @(posedge clk) begin
            if (wr_en && (wr_bank == 1'(b))) begin
                store[wr_addr] <= wr_data;
            end
        end

        assign bank_word[b] = store[rd_addr];
    end

    // Registered read port; idle cycles present zero
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= bank_word[rd_bank];
        end else begin
            rdata <= '0;
        end
    end

endmodule

// File: rtl/pktbuf_ctrl.sv
module pktbuf_ctrl
    import pktbuf_pkg::*;
#(
    parameter ep_dir_e DIR        = DIR_IN,
    parameter int      BANK_BYTES = DEF_BANK_BYTES,
    parameter int      CNT_W      = $clog2(BANK_BYTES + 1),
    parameter int      PTR_W      = $clog2(BANK_BYTES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  prod_ctl_t        prod,
    input  logic [CNT_W-1:0] prod_len,
    input  cons_ctl_t        cons,
    output logic             wr_en,
    output logic             wr_bank,
    output logic [PTR_W-1:0] wr_addr,
    output logic             rd_en,
    output logic             rd_bank,
    output logic [PTR_W-1:0] rd_addr,
    output logic             head_valid,
    output logic [CNT_W-1:0] head_cnt,
    output logic             buf_avail,
    output logic             ev_pkt,
    output logic             underflow,
    output logic             overflow
);

    localparam logic [CNT_W-1:0] LIMIT    = CNT_W'(BANK_BYTES);
    localparam logic [PTR_W-1:0] RPTR_TOP = {PTR_W{1'b1}};

    // Bank state
    logic [NUM_BANKS-1:0] full_q;
    logic [CNT_W-1:0]     cnt_q [NUM_BANKS];
    logic                 head_q;   // oldest full bank
    logic                 tail_q;   // bank being filled
    logic [CNT_W-1:0]     wptr_q;   // fill offset, 0..BANK_BYTES
    logic [PTR_W-1:0]     rptr_q;   // read offset in head bank
    logic                 udf_q;
    logic                 ovf_q;
    logic                 ev_q;

    ctl_dec_t         dec;
    logic [CNT_W-1:0] commit_cnt;

    // Decode this cycle's requests against the bank state
    always_comb begin
        dec.accept_wr     = prod.wr && !full_q[tail_q] && (wptr_q < LIMIT);
        dec.drop_wr       = prod.wr && !dec.accept_wr;
        dec.accept_commit = prod.commit && !full_q[tail_q];
        dec.accept_rd     = cons.rd && full_q[head_q];
        dec.miss_rd       = cons.rd && (full_q == '0);
        dec.accept_rel    = cons.rel && full_q[head_q];
    end

    assign commit_cnt = CNT_W'(clamp_len(int'(prod_len), BANK_BYTES));

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            full_q <= '0;
            for (int b = 0; b < NUM_BANKS; b++) begin
                cnt_q[b] <= '0;
            end
            head_q <= 1'b0;
            tail_q <= 1'b0;
            wptr_q <= '0;
            rptr_q <= '0;
            udf_q  <= 1'b0;
            ovf_q  <= 1'b0;
            ev_q   <= 1'b0;
        end else begin
            // Producer: byte fill, then close the packet
            if (dec.accept_wr) begin
                wptr_q <= wptr_q + 1'b1;
            end
            if (dec.accept_commit) begin
                full_q[tail_q] <= 1'b1;
                cnt_q[tail_q]  <= commit_cnt;
                tail_q         <= ~tail_q;
                wptr_q         <= '0;
            end

            // Consumer: byte drain, then hand the bank back
            if (dec.accept_rd && (rptr_q != RPTR_TOP)) begin
                rptr_q <= rptr_q + 1'b1;
            end
            if (dec.accept_rel) begin
                full_q[head_q] <= 1'b0;
                cnt_q[head_q]  <= '0;
                head_q         <= ~head_q;
                rptr_q         <= '0;
            end

            // Sticky error flags
            if (dec.miss_rd) begin
                udf_q <= 1'b1;
            end
            if (dec.drop_wr) begin
                ovf_q <= 1'b1;
            end

            // Event: sent for IN, arrived for OUT
            ev_q <= (DIR == DIR_IN) ? dec.accept_rel : dec.accept_commit;
        end
    end

    // Memory control
    assign wr_en   = dec.accept_wr && !flush;
    assign wr_bank = tail_q;
    assign wr_addr = wptr_q[PTR_W-1:0];
    assign rd_en   = dec.accept_rd && !flush;
    assign rd_bank = head_q;
    assign rd_addr = rptr_q;

    // Status
    assign head_valid = full_q[head_q];
    assign head_cnt   = cnt_q[head_q];
    assign buf_avail  = !full_q[tail_q];
    assign ev_pkt     = ev_q;
    assign underflow  = udf_q;
    assign overflow   = ovf_q;

    // Assertions guarding bank order, stall, flags and flush
    AST_HEAD_IS_OLDEST: assert property (@(posedge clk) disable iff (rst)
        (full_q != '0) |-> full_q[head_q]);                               // R4

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        ((&full_q) && !cons.rel && !flush) |=> ((&full_q) && $stable(tail_q))); // R6

    AST_EMPTY_READ_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (cons.rd && (full_q == '0) && !flush) |=> udf_q);                 // R8

    AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (rst)
        (udf_q && !flush) |=> udf_q);                                     // R8

    AST_NO_OVERFLOW_LOSS: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !flush) |=> ovf_q);                                     // R9

    AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (wptr_q == LIMIT) |-> !wr_en);                                    // R9

    AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (rst)
        flush |=> ((full_q == '0) && !udf_q && !ovf_q && (wptr_q == '0))); // R10

endmodule

// File: rtl/pingpong_pkt_buf.sv
module pingpong_pkt_buf
    import pktbuf_pkg::*;
#(
    parameter ep_dir_e DIR        = DIR_IN,
    parameter int      DATA_W     = DEF_DATA_W,
    parameter int      BANK_BYTES = DEF_BANK_BYTES,
    localparam int     CNT_W      = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              spi_stb,
    input  logic              spi_done,
    input  logic [DATA_W-1:0] spi_din,
    input  logic [CNT_W-1:0]  spi_len,
    output logic [DATA_W-1:0] spi_dout,
    input  logic              usb_stb,
    input  logic              usb_done,
    input  logic [DATA_W-1:0] usb_din,
    input  logic [CNT_W-1:0]  usb_len,
    output logic [DATA_W-1:0] usb_dout,
    output logic              head_valid,
    output logic [CNT_W-1:0]  head_cnt,
    output logic              buf_avail,
    output logic              ev_pkt,
    output logic              underflow,
    output logic              overflow
);

    localparam int PTR_W = $clog2(BANK_BYTES);

    prod_ctl_t         prod;
    cons_ctl_t         cons;
    logic [DATA_W-1:0] prod_data;
    logic [CNT_W-1:0]  prod_len;
    logic [DATA_W-1:0] rdata;

    logic              wr_en;
    logic              wr_bank;
    logic [PTR_W-1:0]  wr_addr;
    logic              rd_en;
    logic              rd_bank;
    logic [PTR_W-1:0]  rd_addr;

    pktbuf_portmap #(
        .DIR    (DIR),
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W)
    ) u_map (
        .spi_stb   (spi_stb),
        .spi_done  (spi_done),
        .spi_din   (spi_din),
        .spi_len   (spi_len),
        .spi_dout  (spi_dout),
        .usb_stb   (usb_stb),
        .usb_done  (usb_done),
        .usb_din   (usb_din),
        .usb_len   (usb_len),
        .usb_dout  (usb_dout),
        .rdata     (rdata),
        .prod      (prod),
        .prod_data (prod_data),
        .prod_len  (prod_len),
        .cons      (cons)
    );

    pktbuf_ctrl #(
        .DIR        (DIR),
        .BANK_BYTES (BANK_BYTES),
        .CNT_W      (CNT_W),
        .PTR_W      (PTR_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .prod       (prod),
        .prod_len   (prod_len),
        .cons       (cons),
        .wr_en      (wr_en),
        .wr_bank    (wr_bank),
        .wr_addr    (wr_addr),
        .rd_en      (rd_en),
        .rd_bank    (rd_bank),
        .rd_addr    (rd_addr),
        .head_valid (head_valid),
        .head_cnt   (head_cnt),
        .buf_avail  (buf_avail),
        .ev_pkt     (ev_pkt),
        .underflow  (underflow),
        .overflow   (overflow)
    );

    pktbuf_banks #(
        .DATA_W     (DATA_W),
        .BANK_BYTES (BANK_BYTES),
        .PTR_W      (PTR_W)
    ) u_banks (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_bank (wr_bank),
        .wr_addr (wr_addr),
        .wr_data (prod_data),
        .rd_en   (rd_en),
        .rd_bank (rd_bank),
        .rd_addr (rd_addr),
        .rdata   (rdata)
    );

endmodule

// File: tb/pingpong_pkt_buf_tb_top.sv
`timescale 1ns/1ps
module pingpong_pkt_buf_tb_top;
    import pktbuf_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    // IN instance: host side fills, USB side drains
    logic       s_stb = 0, s_done = 0, u_stb = 0, u_done = 0;
    logic [7:0] s_din = 0, u_din = 8'hFF;
    logic [6:0] s_len = 0, u_len = 7'h7F;
    logic [7:0] s_dout, u_dout;
    logic       hv, ba, ev, udf, ovf;
    logic [6:0] hc;

    // OUT instance: USB side fills, host side drains
    logic       os_stb = 0, os_done = 0, ou_stb = 0, ou_done = 0;
    logic [7:0] os_din = 8'hFF, ou_din = 0;
    logic [6:0] os_len = 7'h7F, ou_len = 0;
    logic [7:0] os_dout, ou_dout;
    logic       o_hv, o_ba, o_ev, o_udf, o_ovf;
    logic [6:0] o_hc;

    pingpong_pkt_buf #(.DIR(DIR_IN)) dut_i (
        .clk(clk), .rst(rst), .flush(flush),
        .spi_stb(s_stb), .spi_done(s_done), .spi_din(s_din), .spi_len(s_len), .spi_dout(s_dout),
        .usb_stb(u_stb), .usb_done(u_done), .usb_din(u_din), .usb_len(u_len), .usb_dout(u_dout),
        .head_valid(hv), .head_cnt(hc), .buf_avail(ba), .ev_pkt(ev),
        .underflow(udf), .overflow(ovf)
    );

    pingpong_pkt_buf #(.DIR(DIR_OUT)) dut_out_i (
        .clk(clk), .rst(rst), .flush(1'b0),
        .spi_stb(os_stb), .spi_done(os_done), .spi_din(os_din), .spi_len(os_len), .spi_dout(os_dout),
        .usb_stb(ou_stb), .usb_done(ou_done), .usb_din(ou_din), .usb_len(ou_len), .usb_dout(ou_dout),
        .head_valid(o_hv), .head_cnt(o_hc), .buf_avail(o_ba), .ev_pkt(o_ev),
        .underflow(o_udf), .overflow(o_ovf)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit done_run = 0;

    task automatic chk(input int act, input int exp, input string req, input string what);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Scoreboard queues filled by the driver
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic       rd_seen = 0;

    always @(posedge clk) rd_seen <= u_stb;

    // Monitor: compares each read result one cycle after its strobe
    always @(negedge clk) begin
        if (rd_seen) begin
            if (exp_q.size() == 0) begin
                chk(1, 0, "R3", "read with no expected item");
            end else begin
                chk(int'(u_dout), int'(exp_q.pop_front()), tag_q.pop_front(), "read byte");
                chk(int'(s_dout), 0, "R11", "producer side dout");
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic prod_wr(input logic [7:0] b);
        s_stb = 1; s_din = b;
        @(negedge clk);
        s_stb = 0;
    endtask

    task automatic prod_commit(input logic [6:0] len);
        s_done = 1; s_len = len;
        @(negedge clk);
        s_done = 0;
    endtask

    task automatic cons_rd(input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        u_stb = 1;
        @(negedge clk);
        u_stb = 0;
    endtask

    task automatic both(input logic [7:0] wb, input logic [7:0] e, input string tag);
        exp_q.push_back(e); tag_q.push_back(tag);
        s_stb = 1; s_din = wb; u_stb = 1;
        @(negedge clk);
        s_stb = 0; u_stb = 0;
    endtask

    task automatic cons_rel();
        u_done = 1;
        @(negedge clk);
        u_done = 0;
    endtask

    task automatic do_flush();
        flush = 1;
        @(negedge clk);
        flush = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        tick();

        // R1 reset state
        chk(hv, 0, "R1", "head_valid");
        chk(hc, 0, "R1", "head_cnt");
        chk(ba, 1, "R1", "buf_avail");
        chk(ev, 0, "R1", "ev_pkt");
        chk(udf, 0, "R1", "underflow");
        chk(ovf, 0, "R1", "overflow");
        chk(u_dout, 0, "R1", "usb_dout");

        // R8 read from empty
        cons_rd(8'h00, "R8");
        chk(udf, 1, "R8", "underflow set");
        tick();
        chk(udf, 1, "R8", "underflow sticky");

        // R10 flush clears sticky flag
        do_flush();
        chk(udf, 0, "R10", "underflow after flush");

        // R2 fill packet A
        for (int i = 0; i < 5; i++) prod_wr(8'hA0 + 8'(i));
        chk(hv, 0, "R2", "not visible before commit");
        prod_commit(7'd5);
        chk(hv, 1, "R2", "head_valid after commit");
        chk(hc, 5, "R2", "head_cnt");
        chk(ba, 1, "R5", "second bank free");

        // R5 fill B while draining A
        for (int i = 0; i < 3; i++) both(8'hB0 + 8'(i), 8'hA0 + 8'(i), "R5");
        prod_commit(7'd3);
        chk(ba, 0, "R6", "buf_avail when both full");
        chk(hc, 5, "R4", "oldest still A");

        // R6 stall: write dropped, commit ignored
        prod_wr(8'hEE);
        chk(ovf, 1, "R6", "overflow on stalled write");
        prod_commit(7'd1);
        chk(hc, 5, "R6", "count after ignored commit");

        cons_rd(8'hA3, "R3");
        cons_rd(8'hA4, "R3");
        tick();
        chk(u_dout, 0, "R3", "dout zero when idle");

        // R4/R11 release A
        cons_rel();
        chk(ev, 1, "R11", "IN sent event");
        chk(hc, 3, "R4", "next packet count");
        chk(ba, 1, "R4", "bank free after release");
        tick();
        chk(ev, 0, "R11", "event one cycle");
        for (int i = 0; i < 3; i++) cons_rd(8'hB0 + 8'(i), "R4");

        // R6 dropped byte must not appear in later packet
        prod_wr(8'hC0);
        prod_wr(8'hC1);
        prod_commit(7'd2);
        cons_rel();
        chk(hc, 2, "R6", "packet C count");
        cons_rd(8'hC0, "R6");
        cons_rd(8'hC1, "R6");
        cons_rel();
        chk(hv, 0, "R4", "empty after releases");

        // R10 flush mid-traffic
        prod_wr(8'hD0);
        prod_wr(8'hD1);
        prod_commit(7'd2);
        prod_wr(8'hE0);
        do_flush();
        chk(hv, 0, "R10", "head_valid after flush");
        chk(ba, 1, "R10", "buf_avail after flush");
        chk(ovf, 0, "R10", "overflow after flush");
        prod_wr(8'hF0);
        prod_commit(7'd1);
        chk(hc, 1, "R10", "count after flush");
        cons_rd(8'hF0, "R10");
        cons_rel();

        // R7 zero-length packet
        prod_commit(7'd0);
        chk(hv, 1, "R7", "zero-length present");
        chk(hc, 0, "R7", "zero-length count");
        cons_rel();
        chk(ev, 1, "R7", "zero-length sent event");
        chk(hv, 0, "R7", "zero-length released");

        // R9 bank limit, R2 length clamp
        for (int i = 0; i < 64; i++) prod_wr(8'(i));
        chk(ovf, 0, "R9", "no overflow at 64");
        prod_wr(8'h5A);
        chk(ovf, 1, "R9", "overflow at 65");
        prod_commit(7'd100);
        chk(hc, 64, "R2", "length clamp");
        for (int i = 0; i < 64; i++) cons_rd(8'(i), "R9");
        cons_rel();
        tick();

        // R12 release on empty
        chk(ev, 0, "R12", "event idle before");
        cons_rel();
        chk(ev, 0, "R12", "no event on empty release");
        chk(hv, 0, "R12", "head_valid");
        chk(ba, 1, "R12", "buf_avail");

        // R11 OUT variant
        ou_stb = 1; ou_din = 8'h11; tick();
        ou_din = 8'h22; tick();
        ou_stb = 0; ou_done = 1; ou_len = 7'd2; tick();
        ou_done = 0;
        chk(o_ev, 1, "R11", "OUT arrived event");
        chk(o_hc, 2, "R11", "OUT count");
        os_stb = 1; tick();
        chk(os_dout, 8'h11, "R11", "OUT host read 0");
        chk(ou_dout, 0, "R11", "OUT producer dout");
        tick();
        os_stb = 0;
        chk(os_dout, 8'h22, "R11", "OUT host read 1");
        os_done = 1; tick();
        os_done = 0;
        chk(o_ev, 0, "R11", "no event on OUT release");
        chk(o_hv, 0, "R11", "OUT empty after release");

        tick();
        tick();
        chk(exp_q.size(), 0, "R3", "scoreboard drained");
        done_run = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule